// File: doc/BRIEF.md
# NAND command and address sequencer

This block turns single memory-mapped accesses into byte cycles on an 8-bit NAND flash bus. A bus master makes a request with a 24-bit address, 32-bit write data and a byte count. For accesses to the flash window, the address itself carries the work order. It holds the phase select, up to two command opcodes, a flag that enables the closing opcode, and the number of address bytes to send. The block then issues command-latch, address-latch and data cycles with a write strobe or a read strobe. It holds the request until the last cycle has finished.

An address sequence longer than the per-access burst limit is split across accesses. The surplus count is kept in a small register. It takes the place of the address-byte field on the next command access, and the opening and closing opcodes are withheld while it is nonzero. Reads collect one flash byte per requested byte into a little-endian word. A separate register window returns the ready/busy pins of two flash devices.

Top module: `nand_cycle_sequencer`

## Requirements
- R1: In the flash window (`req_nand`=1), address bit 19 set marks a data access. For data accesses, the opcode fields and the address-byte field (bits 23:21) are ignored, so no command or address byte is sent for them.
- R2: A command write (bit 19 clear) sends the opening opcode from address bits 10:3 as its first byte, with CLE high and ALE low. This byte is left out when a carried-over address count is nonzero at the time the write is accepted.
- R3: A command write sends address bytes with ALE high and CLE low, taken from the write data lowest byte first. It sends at most ADDR_BURST (4) of them. Any requested count above 4 is stored as the carried-over count.
- R4: The next command write with a nonzero bits 23:21 field sends the stored carry-over count instead of that field. A write whose effective field is zero sets the carried-over count to zero. Data writes count as zero. Reads leave the count unchanged.
- R5: When address bit 20 is set and no carry-over remains after the access, a write sends the closing opcode from address bits 18:11 as its last byte, with CLE high. This applies to command writes and data writes alike.
- R6: A data write sends `req_size` bytes of write data, lowest byte first, with CLE and ALE low and the bus driven. A size of 0 or above 4 means 4.
- R7: A flash-window read pulses the read strobe once per requested byte and sends no write strobe. The first byte read lands in bits 7:0, the next in 15:8, and so on. Unrequested upper bytes read as zero.
- R8: In the register window (`req_nand`=0), a read at address 0 returns `nf_rb[0]` in bit 5 and `nf_rb[1]` in bit 6, with all other bits zero. Other addresses read zero. Writes there cause no flash cycles. Register accesses complete with `req_ready` one cycle after acceptance.
- R9: Each flash byte has one setup clock, a strobe held low for STROBE_CLKS clocks (2), and one hold clock. CLE, ALE and the output byte are stable for the whole byte. The write and read strobes are never low together.
- R10: `req_ready` pulses for one cycle, and only after the hold clock of the final byte. A one-byte command access completes STROBE_CLKS+5 cycles after `req_valid` is first presented. A held request is not accepted again while a sequence is running.
- R11: After reset, both strobes are high, CLE, ALE, `nf_io_oe` and `req_ready` are low, and the carried-over count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_ready | output | 1 | One-cycle completion pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_nand | input | 1 | 1 = flash window, 0 = register window |
| req_addr | input | ADDR_W (24) | Access address with the encoded work order |
| req_wdata | input | DATA_W (32) | Write data: address bytes or data bytes |
| req_size | input | 3 | Byte count 1..4 |
| req_rdata | output | DATA_W (32) | Read result, valid with `req_ready` |
| nf_io_out | output | 8 | Byte driven onto the flash bus |
| nf_io_oe | output | 1 | Output enable for the flash bus |
| nf_io_in | input | 8 | Byte read from the flash bus |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Active-low write strobe |
| nf_re_n | output | 1 | Active-low read strobe |
| nf_rb | input | NUM_RB (2) | Ready/busy pins of the flash devices |

## Verification
The bench goes after the carry-over rules. It sends a six-byte request, then a write with a different nonzero field. A design that trusts the field instead of the stored count sends the wrong number of address bytes. A design that forgets to withhold the opcodes sends a stray CLE byte. A zero-field write, a data write and a read each follow an overflow. If any of them clears or keeps the count wrongly, the opening opcode is withheld or sent on the following write when it should not be. Data accesses with nonzero opcode and count fields catch a phase decode that leaks command bytes. The strobe width of every logged byte and the cycle count to `req_ready` catch an early completion or a shortened strobe.

// File: rtl/nseq_pkg.sv
`timescale 1ns/1ps
package nseq_pkg;
   localparam int ACYC_W = 3;

   typedef enum logic [1:0] {
      BK_CMD  = 2'd0,
      BK_ADDR = 2'd1,
      BK_WDAT = 2'd2,
      BK_RDAT = 2'd3
   } bkind_e;

   typedef struct packed {
      logic              data_ph;
      logic              end_ok;
      logic [7:0]        op_start;
      logic [7:0]        op_end;
      logic [ACYC_W-1:0] acyc;
   } acc_dec_t;

   typedef struct packed {
      logic              rd;
      logic              do_start;
      logic [ACYC_W-1:0] n_addr;
      logic [2:0]        n_data;
      logic              do_end;
      logic [ACYC_W-1:0] pend_nxt;
   } acc_plan_t;
endpackage

// File: rtl/nseq_decode.sv
`timescale 1ns/1ps
module nseq_decode
   import nseq_pkg::*;
(
   input  logic [20:0] fld,   // access address bits 23:3
   output acc_dec_t    dec
);
   localparam int PH_BIT  = 16;  // address bit 19
   localparam int EOK_BIT = 17;  // address bit 20
   localparam int CNT_LSB = 18;  // address bits 23:21

   always_comb begin
      dec.data_ph  = fld[PH_BIT];
      dec.end_ok   = fld[EOK_BIT];
      dec.op_start = fld[7:0];
      dec.op_end   = fld[15:8];
      dec.acyc     = fld[PH_BIT] ? '0 : fld[CNT_LSB +: ACYC_W];
   end
endmodule

// File: rtl/nseq_plan.sv
`timescale 1ns/1ps
module nseq_plan
   import nseq_pkg::*;
#(
   parameter int BURST = 4,
   parameter int MAXB  = 4
) (
   input  acc_dec_t          dec,
   input  logic              is_wr,
   input  logic [2:0]        size,
   input  logic [ACYC_W-1:0] pend,
   output acc_plan_t         plan
);
   localparam logic [ACYC_W-1:0] BURST_C = ACYC_W'(BURST);
   localparam logic [2:0]        MAXB_C  = 3'(MAXB);

   logic [2:0]        nbytes;
   logic [ACYC_W-1:0] eff;

   always_comb begin
      nbytes = (size == 3'd0 || size > MAXB_C) ? MAXB_C : size;
      eff           = '0;
      plan          = '0;
      plan.pend_nxt = pend;
      if (!is_wr) begin
         plan.rd     = 1'b1;
         plan.n_data = nbytes;
      end else if (dec.data_ph) begin
         plan.n_data   = nbytes;
         plan.pend_nxt = '0;
         plan.do_end   = dec.end_ok;
      end else begin
         plan.do_start = (pend == '0);
         if (dec.acyc == '0)
            eff = '0;
         else if (pend != '0)
            eff = pend;
         else
            eff = dec.acyc;
         if (eff > BURST_C) begin
            plan.n_addr   = BURST_C;
            plan.pend_nxt = eff - BURST_C;
         end else begin
            plan.n_addr   = eff;
            plan.pend_nxt = '0;
         end
         plan.do_end = dec.end_ok && (plan.pend_nxt == '0);
      end
   end
endmodule

// File: rtl/nseq_strobe.sv
`timescale 1ns/1ps
module nseq_strobe
   import nseq_pkg::*;
#(
   parameter int STROBE_CLKS = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  bkind_e     kind,
   input  logic [7:0] byte_out,
   input  logic [7:0] io_in,
   output logic       busy,
   output logic       done,
   output logic [7:0] rd_byte,
   output logic       cle,
   output logic       ale,
   output logic       we_n,
   output logic       re_n,
   output logic [7:0] io_out,
   output logic       io_oe
);
   localparam int CW = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;

   typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HOLD} ph_e;

   ph_e        ph;
   bkind_e     kind_q;
   logic [7:0] byte_q;
   logic       last_low;

   generate
      if (STROBE_CLKS == 1) begin : g_single
         assign last_low = 1'b1;
      end else begin : g_count
         localparam logic [CW-1:0] LAST = CW'(STROBE_CLKS - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (ph != PH_LOW)
               cnt <= '0;
            else if (cnt != LAST)
               cnt <= cnt + CW'(1);
         end
         assign last_low = (cnt == LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_IDLE;
         kind_q  <= BK_CMD;
         byte_q  <= '0;
         rd_byte <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (ph)
            PH_IDLE: if (go) begin
               ph     <= PH_SETUP;
               kind_q <= kind;
               byte_q <= byte_out;
            end
            PH_SETUP: ph <= PH_LOW;
            PH_LOW: if (last_low) begin
               ph <= PH_HOLD;
               if (kind_q == BK_RDAT) rd_byte <= io_in;
            end
            default: begin
               ph   <= PH_IDLE;
               done <= 1'b1;
            end
         endcase
      end
   end

   always_comb begin
      busy   = (ph != PH_IDLE);
      cle    = busy && (kind_q == BK_CMD);
      ale    = busy && (kind_q == BK_ADDR);
      io_oe  = busy && (kind_q != BK_RDAT);
      io_out = io_oe ? byte_q : 8'h00;
      we_n   = !((ph == PH_LOW) && (kind_q != BK_RDAT));
      re_n   = !((ph == PH_LOW) && (kind_q == BK_RDAT));
   end
endmodule

// File: rtl/nand_cycle_sequencer.sv
`timescale 1ns/1ps
module nand_cycle_sequencer
   import nseq_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int DATA_W      = 32,
   parameter int STROBE_CLKS = 2,
   parameter int ADDR_BURST  = 4,
   parameter int NUM_RB      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_nand,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [2:0]        req_size,
   output logic [DATA_W-1:0] req_rdata,
   output logic [7:0]        nf_io_out,
   output logic              nf_io_oe,
   input  logic [7:0]        nf_io_in,
   output logic              nf_cle,
   output logic              nf_ale,
   output logic              nf_we_n,
   output logic              nf_re_n,
   input  logic [NUM_RB-1:0] nf_rb
);
   localparam int BYTES  = DATA_W / 8;
   localparam int IDX_W  = $clog2(BYTES);
   localparam int RB_LSB = 5;

   generate
      if (ADDR_W < 24) begin : g_bad_addr
         $error("ADDR_W must be at least 24");
      end
      if (DATA_W != 16 && DATA_W != 32) begin : g_bad_data
         $error("DATA_W must be 16 or 32");
      end
      if (ADDR_BURST < 1 || ADDR_BURST > BYTES) begin : g_bad_burst
         $error("ADDR_BURST must be 1..DATA_W/8");
      end
      if (STROBE_CLKS < 1) begin : g_bad_strobe
         $error("STROBE_CLKS must be at least 1");
      end
      if (NUM_RB < 1 || NUM_RB > DATA_W - RB_LSB) begin : g_bad_rb
         $error("NUM_RB out of range");
      end
   endgenerate

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_e;

   st_e               st;
   acc_dec_t          dec;
   acc_plan_t         plan;
   logic [ACYC_W-1:0] pend_q;
   logic              do_start_q, do_end_q, rd_q;
   logic [ACYC_W-1:0] addr_left;
   logic [2:0]        data_left;
   logic [IDX_W-1:0]  idx_q, rd_pos;
   logic [DATA_W-1:0] wdata_q, rdata_q, status_w;
   logic [7:0]        op_s, op_e;

   logic              have_item, go, eng_busy, eng_done;
   bkind_e            go_kind;
   logic [7:0]        go_byte, eng_rd;

   nseq_decode u_dec (
      .fld (req_addr[23:3]),
      .dec (dec)
   );

   nseq_plan #(.BURST(ADDR_BURST), .MAXB(BYTES)) u_plan (
      .dec   (dec),
      .is_wr (req_write),
      .size  (req_size),
      .pend  (pend_q),
      .plan  (plan)
   );

   nseq_strobe #(.STROBE_CLKS(STROBE_CLKS)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .kind     (go_kind),
      .byte_out (go_byte),
      .io_in    (nf_io_in),
      .busy     (eng_busy),
      .done     (eng_done),
      .rd_byte  (eng_rd),
      .cle      (nf_cle),
      .ale      (nf_ale),
      .we_n     (nf_we_n),
      .re_n     (nf_re_n),
      .io_out   (nf_io_out),
      .io_oe    (nf_io_oe)
   );

   always_comb begin
      status_w = '0;
      for (int i = 0; i < NUM_RB; i++) status_w[RB_LSB + i] = nf_rb[i];
   end

   // Next byte: opening opcode, address bytes, data bytes, closing opcode.
   always_comb begin
      have_item = do_start_q || (addr_left != '0) || (data_left != '0) || do_end_q;
      go        = (st == ST_RUN) && !eng_busy && have_item;
      if (do_start_q) begin
         go_kind = BK_CMD;
         go_byte = op_s;
      end else if (addr_left != '0) begin
         go_kind = BK_ADDR;
         go_byte = wdata_q[{idx_q, 3'b000} +: 8];
      end else if (data_left != '0) begin
         go_kind = rd_q ? BK_RDAT : BK_WDAT;
         go_byte = wdata_q[{idx_q, 3'b000} +: 8];
      end else begin
         go_kind = BK_CMD;
         go_byte = op_e;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         pend_q     <= '0;
         do_start_q <= 1'b0;
         do_end_q   <= 1'b0;
         rd_q       <= 1'b0;
         addr_left  <= '0;
         data_left  <= '0;
         idx_q      <= '0;
         rd_pos     <= '0;
         wdata_q    <= '0;
         rdata_q    <= '0;
         op_s       <= '0;
         op_e       <= '0;
      end else begin
         case (st)
            ST_IDLE: if (req_valid) begin
               if (!req_nand) begin
                  rdata_q <= (!req_write && req_addr == '0) ? status_w : '0;
                  st      <= ST_DONE;
               end else begin
                  pend_q     <= plan.pend_nxt;
                  do_start_q <= plan.do_start;
                  addr_left  <= plan.n_addr;
                  data_left  <= plan.n_data;
                  do_end_q   <= plan.do_end;
                  rd_q       <= plan.rd;
                  idx_q      <= '0;
                  rd_pos     <= '0;
                  wdata_q    <= req_wdata;
                  op_s       <= dec.op_start;
                  op_e       <= dec.op_end;
                  rdata_q    <= '0;
                  st         <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (go) begin
                  if (do_start_q) begin
                     do_start_q <= 1'b0;
                  end else if (addr_left != '0) begin
                     addr_left <= addr_left - ACYC_W'(1);
                     idx_q     <= idx_q + IDX_W'(1);
                  end else if (data_left != '0) begin
                     data_left <= data_left - 3'd1;
                     idx_q     <= idx_q + IDX_W'(1);
                  end else begin
                     do_end_q <= 1'b0;
                  end
               end
               if (eng_done && rd_q) begin
                  rdata_q[{rd_pos, 3'b000} +: 8] <= eng_rd;
                  rd_pos <= rd_pos + IDX_W'(1);
               end
               if (!eng_busy && !have_item) st <= ST_DONE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (st == ST_DONE);
   assign req_rdata = rdata_q;
endmodule

// File: rtl/nseq_checker.sv
`timescale 1ns/1ps
module nseq_checker
   import nseq_pkg::*;
#(
   parameter int BURST = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              nf_cle,
   input logic              nf_ale,
   input logic              nf_we_n,
   input logic              nf_re_n,
   input logic              nf_io_oe,
   input logic [7:0]        nf_io_out,
   input logic [ACYC_W-1:0] pend_q
);
   localparam logic [ACYC_W-1:0] PEND_MAX = ACYC_W'((1 << ACYC_W) - 1 - BURST);

   AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(nf_cle && nf_ale)); // R2
   AST_PEND_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q <= PEND_MAX); // R3
   AST_WE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      !nf_we_n |-> nf_io_oe); // R6
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nf_we_n && !nf_re_n)); // R9
   AST_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!nf_we_n && $past(!nf_we_n)) |-> ($stable(nf_io_out) && $stable(nf_cle) && $stable(nf_ale))); // R9
   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready); // R10
   AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (nf_we_n && nf_re_n && !nf_cle && !nf_ale)); // R10
endmodule

bind nand_cycle_sequencer nseq_checker #(.BURST(ADDR_BURST)) u_nseq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .nf_cle    (nf_cle),
   .nf_ale    (nf_ale),
   .nf_we_n   (nf_we_n),
   .nf_re_n   (nf_re_n),
   .nf_io_oe  (nf_io_oe),
   .nf_io_out (nf_io_out),
   .pend_q    (pend_q)
);

// File: tb/tb_nand_cycle_sequencer.sv
`timescale 1ns/1ps
module tb_nand_cycle_sequencer;
   localparam int T = 2;
   localparam logic [1:0] K_DAT = 2'b00, K_ALE = 2'b01, K_CLE = 2'b10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_nand = 1'b0;
   logic [23:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [2:0]  req_size = 3'd1;
   logic        req_ready;
   logic [31:0] req_rdata;
   logic [7:0]  nf_io_out, nf_io_in;
   logic        nf_io_oe, nf_cle, nf_ale, nf_we_n, nf_re_n;
   logic [1:0]  nf_rb = 2'b11;

   int nchk = 0, nfail = 0;
   int ev_n = 0, rd_cnt = 0, re_w = 0;
   logic [1:0] ev_kind [0:31];
   logic [7:0] ev_byte [0:31];
   int         ev_w    [0:31];
   time        t_we_fall = 0, t_re_fall = 0;

   always #4 clk = ~clk;   // 125 MHz

   nand_cycle_sequencer #(.STROBE_CLKS(T)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_nand(req_nand), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_size(req_size), .req_rdata(req_rdata),
      .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in),
      .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
      .nf_rb(nf_rb)
   );

   function automatic logic [7:0] pat(input int k);
      return 8'(k * 37 + 5);
   endfunction

   // Flash bus model: logs written bytes, serves read bytes.
   always @(negedge nf_we_n) t_we_fall = $time;
   always @(posedge nf_we_n) if (rst_n === 1'b1 && ev_n < 32) begin
      ev_kind[ev_n] = {nf_cle, nf_ale};
      ev_byte[ev_n] = nf_io_out;
      ev_w[ev_n]    = int'(($time - t_we_fall) / 8);
      ev_n++;
   end
   always @(negedge nf_re_n) t_re_fall = $time;
   always @(posedge nf_re_n) if (rst_n === 1'b1) begin
      re_w = int'(($time - t_re_fall) / 8);
      rd_cnt++;
      nf_io_in = pat(rd_cnt);
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic expect_ev(input string tag, input int i, input logic [1:0] k, input logic [7:0] b);
      chk(tag, {14'b0, ev_kind[i], ev_byte[i], 8'(ev_w[i])}, {14'b0, k, b, 8'(T)});
   endtask

   function automatic logic [23:0] mk(input logic [2:0] acyc, input logic eok, input logic dph,
                                      input logic [7:0] ope, input logic [7:0] ops);
      return {acyc, eok, dph, ope, ops, 3'b000};
   endfunction

   logic [31:0] rd_r;
   int          lat_r, nrdy_r;

   task automatic access(input logic wr, input logic nsel, input logic [23:0] a,
                         input logic [31:0] wd, input logic [2:0] sz);
      @(negedge clk);
      ev_n = 0;
      req_valid = 1'b1; req_write = wr; req_nand = nsel;
      req_addr = a; req_wdata = wd; req_size = sz;
      lat_r = 0;
      forever begin
         @(negedge clk);
         lat_r++;
         if (req_ready || lat_r > 2000) break;
      end
      rd_r = req_rdata;
      nrdy_r = ev_n;
      req_valid = 1'b0;
      @(negedge clk);
      chk("R10 ready drops after one cycle", {31'b0, req_ready}, 32'd0);
   endtask

   task automatic t_reset;
      chk("R11 reset outputs", {26'b0, req_ready, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_io_oe},
          {26'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
   endtask

   task automatic t_first_cmd;
      access(1'b1, 1'b1, mk(3'd0, 1'b0, 1'b0, 8'h00, 8'hFF), 32'h0, 3'd1);
      chk("R11 pending zero after reset: start sent", 32'(nrdy_r), 32'd1);
      expect_ev("R2 start opcode CLE", 0, K_CLE, 8'hFF);
      chk("R10 one-byte latency", 32'(lat_r), 32'(T + 5));
   endtask

   task automatic t_cmd_addr_end;
      access(1'b1, 1'b1, mk(3'd3, 1'b1, 1'b0, 8'h30, 8'h00), 32'h00332211, 3'd4);
      chk("R3 byte count", 32'(nrdy_r), 32'd5);
      expect_ev("R2 start", 0, K_CLE, 8'h00);
      expect_ev("R3 addr0", 1, K_ALE, 8'h11);
      expect_ev("R3 addr1", 2, K_ALE, 8'h22);
      expect_ev("R3 addr2", 3, K_ALE, 8'h33);
      expect_ev("R5 end opcode", 4, K_CLE, 8'h30);
   endtask

   task automatic t_carry;
      access(1'b1, 1'b1, mk(3'd6, 1'b1, 1'b0, 8'h10, 8'h80), 32'h44332211, 3'd4);
      chk("R5 end withheld while pending", 32'(nrdy_r), 32'd5);
      expect_ev("R3 start", 0, K_CLE, 8'h80);
      expect_ev("R3 addr3 last of burst", 4, K_ALE, 8'h44);
      access(1'b1, 1'b1, mk(3'd3, 1'b1, 1'b0, 8'h10, 8'h99), 32'h0000BBAA, 3'd4);
      chk("R4 pending 2 replaces field 3", 32'(nrdy_r), 32'd3);
      expect_ev("R4 no start, addr0", 0, K_ALE, 8'hAA);
      expect_ev("R4 addr1", 1, K_ALE, 8'hBB);
      expect_ev("R5 end after carry", 2, K_CLE, 8'h10);
   endtask

   task automatic t_clear;
      access(1'b1, 1'b1, mk(3'd7, 1'b0, 1'b0, 8'h00, 8'h70), 32'h04030201, 3'd4);
      chk("R3 seven requested, four sent", 32'(nrdy_r), 32'd5);
      access(1'b1, 1'b1, mk(3'd0, 1'b1, 1'b0, 8'hE0, 8'h71), 32'h0, 3'd4);
      chk("R4 zero field: start skipped", 32'(nrdy_r), 32'd1);
      expect_ev("R5 end only", 0, K_CLE, 8'hE0);
      access(1'b1, 1'b1, mk(3'd1, 1'b0, 1'b0, 8'h00, 8'h72), 32'h0000005A, 3'd4);
      chk("R4 cleared: start returns", 32'(nrdy_r), 32'd2);
      expect_ev("R2 start after clear", 0, K_CLE, 8'h72);
      expect_ev("R4 own field used", 1, K_ALE, 8'h5A);
   endtask

   task automatic t_data_write;
      access(1'b1, 1'b1, mk(3'd7, 1'b0, 1'b1, 8'h66, 8'h55), 32'h00CCBBAA, 3'd3);
      chk("R1 data phase ignores fields", 32'(nrdy_r), 32'd3);
      expect_ev("R6 data0", 0, K_DAT, 8'hAA);
      expect_ev("R6 data1", 1, K_DAT, 8'hBB);
      expect_ev("R6 data2", 2, K_DAT, 8'hCC);
      access(1'b1, 1'b1, mk(3'd0, 1'b1, 1'b1, 8'h10, 8'h00), 32'h00000042, 3'd1);
      chk("R5 data then end", 32'(nrdy_r), 32'd2);
      expect_ev("R6 single byte", 0, K_DAT, 8'h42);
      expect_ev("R5 end after data", 1, K_CLE, 8'h10);
      access(1'b1, 1'b1, mk(3'd0, 1'b0, 1'b1, 8'h00, 8'h00), 32'h0D0C0B0A, 3'd0);
      chk("R6 size 0 means 4", 32'(nrdy_r), 32'd4);
      expect_ev("R6 size0 last byte", 3, K_DAT, 8'h0D);
   endtask

   task automatic t_data_clears;
      access(1'b1, 1'b1, mk(3'd5, 1'b0, 1'b0, 8'h00, 8'h60), 32'h0, 3'd4);
      access(1'b1, 1'b1, mk(3'd0, 1'b0, 1'b1, 8'h00, 8'h00), 32'h000000EE, 3'd1);
      access(1'b1, 1'b1, mk(3'd1, 1'b0, 1'b0, 8'h00, 8'h61), 32'h00000077, 3'd4);
      chk("R4 data write cleared pending", 32'(nrdy_r), 32'd2);
      expect_ev("R4 start after data", 0, K_CLE, 8'h61);
      expect_ev("R4 addr", 1, K_ALE, 8'h77);
   endtask

   task automatic t_read;
      int b;
      b = rd_cnt;
      access(1'b0, 1'b1, mk(3'd0, 1'b0, 1'b1, 8'h00, 8'h00), 32'h0, 3'd4);
      chk("R7 four bytes packed", rd_r, {pat(b + 3), pat(b + 2), pat(b + 1), pat(b)});
      chk("R7 read strobes", 32'(rd_cnt - b), 32'd4);
      chk("R7 no write strobes", 32'(nrdy_r), 32'd0);
      chk("R9 read strobe width", 32'(re_w), 32'(T));
      b = rd_cnt;
      access(1'b0, 1'b1, mk(3'd0, 1'b0, 1'b1, 8'h00, 8'h00), 32'h0, 3'd2);
      chk("R7 upper bytes zero", rd_r, {16'h0, pat(b + 1), pat(b)});
      access(1'b1, 1'b1, mk(3'd5, 1'b0, 1'b0, 8'h00, 8'h62), 32'h0, 3'd4);
      access(1'b0, 1'b1, mk(3'd0, 1'b0, 1'b1, 8'h00, 8'h00), 32'h0, 3'd1);
      access(1'b1, 1'b1, mk(3'd1, 1'b0, 1'b0, 8'h00, 8'h63), 32'h00000031, 3'd4);
      chk("R7 read keeps pending", 32'(nrdy_r), 32'd1);
      expect_ev("R7 carried addr byte", 0, K_ALE, 8'h31);
   endtask

   task automatic t_status;
      nf_rb = 2'b01;
      access(1'b0, 1'b0, 24'h0, 32'h0, 3'd4);
      chk("R8 ready0 in bit 5", rd_r, 32'h20);
      chk("R8 register latency", 32'(lat_r), 32'd1);
      nf_rb = 2'b10;
      access(1'b0, 1'b0, 24'h0, 32'h0, 3'd4);
      chk("R8 ready1 in bit 6", rd_r, 32'h40);
      nf_rb = 2'b11;
      access(1'b0, 1'b0, 24'h4, 32'h0, 3'd4);
      chk("R8 other offset reads zero", rd_r, 32'h0);
      access(1'b1, 1'b0, 24'h0, 32'hFFFFFFFF, 3'd4);
      chk("R8 register write no flash cycles", 32'(ev_n), 32'd0);
   endtask

   initial begin
      nf_io_in = pat(0);
      repeat (5) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      t_reset;
      t_first_cmd;
      t_cmd_addr_end;
      t_carry;
      t_clear;
      t_data_write;
      t_data_clears;
      t_read;
      t_status;
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end
endmodule